// File: doc/BRIEF.md
# Beam Phase and Amplitude Detector

This block measures where the circulating beam sits in phase against the accelerating RF. A digitised beam pickup sample first passes through a programmable second-order recursive bandpass section. The filtered value is then multiplied by a sine and cosine reference pair that comes from the oscillator and has already been delayed to match the beam path. The two products form the in-phase and quadrature beam components. These components leave the block early, with their own strobe, for use by feed-forward beam-loading compensation.

The same I/Q pair then enters a pipelined vectoring rotator. After 16 shift-and-add steps it produces the beam phase angle over the whole circle, for the phase loop. It also produces a vector magnitude, carrying the fixed rotator gain, for the bunch-length correction. Vectors in the left half-plane are first turned by a quarter turn so that every angle converges. One sample can enter on each clock, and every result comes out a fixed number of cycles later. The loop compensators that use these outputs are outside the block.

Top module: `beam_phase_detector`

## Requirements
- R1: While `rst_n` is low, `iq_valid`, `out_valid`, `beam_i`, `beam_q`, `phase` and `magnitude` are zero. A sample that is still in flight when reset is applied never produces a result strobe.
- R2: On each cycle with `in_valid` high, the filter computes y = sat16((b0·x[n] + b1·x[n-1] + b2·x[n-2] − a1·y[n-1] − a2·y[n-2]) >>> 14). The coefficients are signed with 14 fraction bits, and the arithmetic shift rounds toward minus infinity. The filter history advances only on cycles with `in_valid` high.
- R3: `beam_i` = sat16((y·ref_cos) >>> 15) and `beam_q` = sat16((y·ref_sin) >>> 15). The references are signed with 15 fraction bits and are captured on the same edge as the sample, so a later change of the reference inputs has no effect on that sample.
- R4: `iq_valid` is high in the cycle after the second rising edge, counting the edge that takes the sample. `beam_i` and `beam_q` change only on an edge that raises `iq_valid`.
- R5: `phase` equals atan2(beam_q, beam_i) in two's complement, with 32768 LSB equal to π, so that +π and −π both read as −32768. The error is at most 12 LSB for vectors of magnitude 1024 or more, in all four quadrants.
- R6: `magnitude` equals 1.64676·sqrt(beam_i² + beam_q²) within 0.5 % plus 4 LSB.
- R7: `out_valid`, together with its `phase` and `magnitude`, is high in the cycle after the 18th rising edge, counting the edge that takes the sample. Samples on consecutive cycles give results on consecutive cycles.
- R8: A mixer product outside the signed 16-bit range is clipped to 32767 or −32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beam sample and reference pair present |
| beam_sample | input | 16 | Signed beam pickup sample |
| ref_sin | input | 16 | Delayed reference sine, Q1.15 |
| ref_cos | input | 16 | Delayed reference cosine, Q1.15 |
| coef_b0 | input | 16 | Filter feed-forward tap 0, Q2.14 |
| coef_b1 | input | 16 | Filter feed-forward tap 1, Q2.14 |
| coef_b2 | input | 16 | Filter feed-forward tap 2, Q2.14 |
| coef_a1 | input | 16 | Filter feedback tap 1, Q2.14 |
| coef_a2 | input | 16 | Filter feedback tap 2, Q2.14 |
| iq_valid | output | 1 | Strobe for beam_i and beam_q |
| beam_i | output | 16 | In-phase beam component |
| beam_q | output | 16 | Quadrature beam component |
| out_valid | output | 1 | Strobe for phase and magnitude |
| phase | output | 16 | Beam phase, 32768 LSB equal to π |
| magnitude | output | 18 | Beam vector magnitude including rotator gain |

## Verification
The detector is driven with a fixed-amplitude sample against reference pairs placed on both axes, on all four diagonals and at exactly π. These cases separate the quarter-turn pre-rotation paths from the plain iteration path and show how the phase wraps at the ±π seam. Negative samples, short vectors and near-axis vectors then test sign handling and truncation loss. A reference at full negative scale tests mixer clipping. A burst of back-to-back samples shows that results stay in order and aligned with their strobe. A run with non-trivial coefficients, idle gaps between samples and references changed after capture separates correct filter recursion from history that advances on idle cycles.

// File: rtl/beam_phase_detector.sv
`timescale 1ns/1ps
module beam_phase_detector #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int ITER = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] beam_sample,
  input  logic signed [DW-1:0] ref_sin,
  input  logic signed [DW-1:0] ref_cos,
  input  logic signed [CW-1:0] coef_b0,
  input  logic signed [CW-1:0] coef_b1,
  input  logic signed [CW-1:0] coef_b2,
  input  logic signed [CW-1:0] coef_a1,
  input  logic signed [CW-1:0] coef_a2,
  output logic                 iq_valid,
  output logic signed [DW-1:0] beam_i,
  output logic signed [DW-1:0] beam_q,
  output logic                 out_valid,
  output logic signed [15:0]   phase,
  output logic [DW+1:0]        magnitude
);

  localparam int GW  = 2;
  localparam int W   = DW + 3 + GW;
  localparam int MW  = DW + 2;
  localparam int LAT = ITER + 2;
  localparam logic signed [47:0] SAT_HI = (48'sd1 <<< (DW-1)) - 48'sd1;
  localparam logic signed [47:0] SAT_LO = -(48'sd1 <<< (DW-1));

  function automatic logic signed [DW-1:0] clip(input logic signed [47:0] v);
    if (v > SAT_HI) return SAT_HI[DW-1:0];
    if (v < SAT_LO) return SAT_LO[DW-1:0];
    return v[DW-1:0];
  endfunction

  function automatic logic [15:0] atan_step(input int k);
    case (k)
      0: return 16'd8192;  1: return 16'd4836;  2: return 16'd2555;  3: return 16'd1297;
      4: return 16'd651;   5: return 16'd326;   6: return 16'd163;   7: return 16'd81;
      8: return 16'd41;    9: return 16'd20;   10: return 16'd10;   11: return 16'd5;
      12: return 16'd3;   13: return 16'd1;    14: return 16'd1;
      default: return 16'd0;
    endcase
  endfunction

  logic [LAT-1:0] vld;
  logic signed [DW-1:0] x1, x2, y1, y2, rs_q, rc_q, filt;
  logic signed [47:0] acc, prod_i, prod_q;

  assign acc = 48'(coef_b0) * 48'(beam_sample) + 48'(coef_b1) * 48'(x1)
             + 48'(coef_b2) * 48'(x2) - 48'(coef_a1) * 48'(y1) - 48'(coef_a2) * 48'(y2);
  assign filt = clip(acc >>> (CW-2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1 <= '0; x2 <= '0; y1 <= '0; y2 <= '0; rs_q <= '0; rc_q <= '0;
    end else if (in_valid) begin
      x1 <= beam_sample; x2 <= x1;
      y1 <= filt;        y2 <= y1;
      rs_q <= ref_sin;   rc_q <= ref_cos;
    end
  end

  assign prod_i = 48'(y1) * 48'(rc_q);
  assign prod_q = 48'(y1) * 48'(rs_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beam_i <= '0; beam_q <= '0;
    end else if (vld[0]) begin
      beam_i <= clip(prod_i >>> (DW-1));
      beam_q <= clip(prod_q >>> (DW-1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else        vld <= {vld[LAT-2:0], in_valid};
  end

  assign iq_valid  = vld[1];
  assign out_valid = vld[LAT-1];

  logic signed [W-1:0] wi, wq, px, py;
  logic [15:0] pz;

  assign wi = {{(W-DW){beam_i[DW-1]}}, beam_i} <<< GW;
  assign wq = {{(W-DW){beam_q[DW-1]}}, beam_q} <<< GW;

  always_comb begin
    if (!wi[W-1]) begin
      px = wi;  py = wq;  pz = 16'h0000;
    end else if (!wq[W-1]) begin
      px = wq;  py = -wi; pz = 16'h4000;
    end else begin
      px = -wq; py = wi;  pz = 16'hC000;
    end
  end

  for (genvar k = 0; k < ITER; k++) begin : g_iter
    logic signed [W-1:0] xi, yi, xo, yo;
    logic [15:0] zi, zo;
    if (k == 0) begin : g_in
      assign xi = px; assign yi = py; assign zi = pz;
    end else begin : g_in
      assign xi = g_iter[k-1].xo; assign yi = g_iter[k-1].yo; assign zi = g_iter[k-1].zo;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        xo <= '0; yo <= '0; zo <= '0;
      end else if (!yi[W-1]) begin
        xo <= xi + (yi >>> k); yo <= yi - (xi >>> k); zo <= zi + atan_step(k);
      end else begin
        xo <= xi - (yi >>> k); yo <= yi + (xi >>> k); zo <= zi - atan_step(k);
      end
    end
  end

  logic signed [W-1:0] x_end, y_end;
  assign x_end     = g_iter[ITER-1].xo;
  assign y_end     = g_iter[ITER-1].yo;
  assign phase     = g_iter[ITER-1].zo;
  assign magnitude = x_end[MW+GW-1:GW];

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!iq_valid && !out_valid && beam_i == 0 && beam_q == 0 && phase == 0 && magnitude == 0));

  assert_iq_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 iq_valid);

  assert_iq_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !iq_valid |-> ($stable(beam_i) && $stable(beam_q)));

  assert_result_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##LAT out_valid);

  assert_vector_converged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!x_end[W-1] && y_end < 512 && y_end > -512));

endmodule

// File: tb/beam_phase_detector_test.sv
`timescale 1ns/1ps
module beam_phase_detector_test;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic signed [15:0] beam_sample = '0, ref_sin = '0, ref_cos = '0;
  logic signed [15:0] cb0 = 16'sd16384, cb1 = '0, cb2 = '0, ca1 = '0, ca2 = '0;
  logic iq_valid, out_valid;
  logic signed [15:0] beam_i, beam_q, phase;
  logic [17:0] magnitude;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  beam_phase_detector uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .beam_sample(beam_sample),
    .ref_sin(ref_sin), .ref_cos(ref_cos), .coef_b0(cb0), .coef_b1(cb1), .coef_b2(cb2),
    .coef_a1(ca1), .coef_a2(ca2), .iq_valid(iq_valid), .beam_i(beam_i), .beam_q(beam_q),
    .out_valid(out_valid), .phase(phase), .magnitude(magnitude));

  // {sample, sin, cos}
  localparam logic [47:0] TBL [10] = '{
    {16'sd20000,  16'sd0,      16'sd32767},
    {16'sd20000,  16'sd32767,  16'sd0},
    {16'sd20000,  16'sd23170, -16'sd23170},
    {16'sd20000, -16'sd23170, -16'sd23170},
    {16'sd20000,  16'sd0,     -16'sd32767},
    {16'sd20000, -16'sd23170,  16'sd23170},
    {-16'sd12000, 16'sd12000,  16'sd30000},
    {16'sd3000,   16'sd30000, -16'sd13000},
    {16'sd32767,  16'sd10,     16'sd32767},
    {-16'sd30000,-16'sd32767,  16'sd5}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint mixv(input longint y, input longint r);
    return sat16((y * r) >>> 15);
  endfunction

  task automatic check_result(input longint ei, input longint eq);
    real a, m;
    longint ep, d, em;
    a  = $atan2(real'(eq), real'(ei)) * 32768.0 / 3.14159265358979;
    ep = longint'($rtoi(a + (a >= 0.0 ? 0.5 : -0.5)));
    d  = longint'(phase) - ep;
    d  = ((d % 65536) + 65536 + 32768) % 65536 - 32768;
    check(d <= 12 && d >= -12, "R5", "phase", longint'(phase), ep);
    m  = 1.6467602 * $sqrt(real'(ei * ei + eq * eq));
    em = longint'($rtoi(m + 0.5));
    check(real'(magnitude) <= m * 1.005 + 4.0 && real'(magnitude) >= m * 0.995 - 4.0,
          "R6", "magnitude", longint'(magnitude), em);
  endtask

  task automatic full_run(input longint smp, input longint s, input longint c);
    longint ei, eq;
    ei = mixv(smp, c);
    eq = mixv(smp, s);
    @(negedge clk);
    in_valid = 1'b1; beam_sample = 16'(smp); ref_sin = 16'(s); ref_cos = 16'(c);
    @(negedge clk);
    in_valid = 1'b0; beam_sample = '0; ref_sin = 16'sd777; ref_cos = -16'sd999;
    @(negedge clk);
    check(iq_valid == 1'b1, "R4", "iq_valid", longint'(iq_valid), 1);
    check(beam_i == ei, "R3", "beam_i", longint'(beam_i), ei);
    check(beam_q == eq, "R3", "beam_q", longint'(beam_q), eq);
    repeat (15) @(negedge clk);
    check(out_valid == 1'b0, "R7", "out_valid early", longint'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R7", "out_valid", longint'(out_valid), 1);
    check_result(ei, eq);
  endtask

  task automatic check_clear(input string what);
    check(!iq_valid && !out_valid && beam_i == 0 && beam_q == 0 && phase == 0 && magnitude == 0,
          "R1", what, longint'(magnitude) + longint'(out_valid) + longint'(iq_valid), 0);
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL R7 watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint si [4], ei [4], eq [4];
    longint mx1, mx2, my1, my2, y, hits;
    longint fx [5];
    repeat (3) @(negedge clk);
    check_clear("outputs in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int n = 0; n < 10; n++)
      full_run(longint'($signed(TBL[n][47:32])), longint'($signed(TBL[n][31:16])),
               longint'($signed(TBL[n][15:0])));

    // R8: clipping of the cosine product at full negative scale
    full_run(-32768, 32767, -32768);
    check(beam_i == 16'sd32767, "R8", "clipped beam_i", longint'(beam_i), 32767);

    // R7: back-to-back burst
    for (int k = 0; k < 4; k++) begin
      si[k] = 6000 + 5000 * k;
      ei[k] = mixv(si[k], 23170 - 9000 * k);
      eq[k] = mixv(si[k], -20000 + 11000 * k);
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b1; beam_sample = 16'(si[k]);
      ref_cos = 16'(23170 - 9000 * k); ref_sin = 16'(-20000 + 11000 * k);
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (14) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check(out_valid == 1'b1, "R7", "burst out_valid", longint'(out_valid), 1);
      check_result(ei[k], eq[k]);
      @(negedge clk);
    end
    check(out_valid == 1'b0, "R7", "burst end", longint'(out_valid), 0);

    // R1: reset while a sample is in flight
    @(negedge clk);
    in_valid = 1'b1; beam_sample = 16'sd15000; ref_cos = 16'sd20000; ref_sin = 16'sd9000;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_clear("outputs after mid-run reset");
    rst_n = 1'b1;
    hits = 0;
    repeat (20) begin
      @(negedge clk);
      if (out_valid) hits++;
    end
    check(hits == 0, "R1", "flushed sample strobes", hits, 0);

    // R2: filter recursion with idle gaps and changed references
    rst_n = 1'b0;
    cb0 = 16'sd8192; cb1 = 16'sd4096; cb2 = -16'sd2048; ca1 = -16'sd8192; ca2 = 16'sd4096;
    @(negedge clk);
    rst_n = 1'b1;
    fx = '{10000, 0, -5000, 3000, 0};
    mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
    for (int n = 0; n < 5; n++) begin
      y = sat16((8192 * fx[n] + 4096 * mx1 - 2048 * mx2 + 8192 * my1 - 4096 * my2) >>> 14);
      @(negedge clk);
      in_valid = 1'b1; beam_sample = 16'(fx[n]); ref_cos = 16'sd32767; ref_sin = 16'sd16384;
      @(negedge clk);
      in_valid = 1'b0; beam_sample = 16'sd31000; ref_cos = '0; ref_sin = '0;
      @(negedge clk);
      check(beam_i == mixv(y, 32767), "R2", "filtered beam_i", longint'(beam_i), mixv(y, 32767));
      check(beam_q == mixv(y, 16384), "R3", "captured ref beam_q", longint'(beam_q), mixv(y, 16384));
      mx2 = mx1; mx1 = fx[n]; my2 = my1; my1 = y;
      repeat (3) @(negedge clk);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule